// File: doc/BRIEF.md
# Multicore Global Configuration Register Block

This block is a small memory-mapped register file shared by up to eight virtual processors (VPs). It holds a handful of global words: its own relocatable base, a revision word, two peripheral base registers (interrupt controller and power controller), each with an address field and an enable bit, two presence status words and a cache-configuration word. Each peripheral base register accepts writes only while that peripheral is flagged present. The block decodes the base registers into address and enable outputs that the fabric uses to place those peripherals.

Each VP also owns a private bank with a reset-vector base register and a target selector. The bank is reachable through two windows of the address map. The local window always reaches the bank of the VP issuing the access. The remote window reaches the bank named by the requester's own selector. So one offset in the remote window lands in different banks depending on which VP issues the access. Each VP's reset-vector base is exported at all times as a 64-bit, sign-extended exception base.

The bus is a plain strobe interface carrying a requester index. Read data is registered. A one-cycle debug flag marks accesses to offsets that map to nothing.

Top module: `vp_gcfg_regs`

## Requirements
- R1: After reset every selector is 0, every reset-vector base reads 0xBFC00000, every exported exception base is 0xFFFFFFFFBFC00000, both peripheral base registers and their enable outputs are 0, and the self base equals parameter SELF_RST.
- R2: Accesses with addr_i[14:13]=1 (local window) reach the bank of VP req_vp_i; offset 0x008 is the reset-vector base and offset 0x010 the selector, within the window.
- R3: A selector write (offset 0x010, value in wdata_i[2:0]) takes effect only when that value is less than NUM_VP; otherwise the selector keeps its old value.
- R4: Accesses with addr_i[14:13]=2 (remote window) reach the bank of the VP held in the requester's selector, for both reads and writes of either bank register.
- R5: Offset 0x000 in either per-VP window reads NUM_VP-1.
- R6: The interrupt-controller base (global 0x018, mask 0xFFFE0001) and power-controller base (global 0x020, mask 0xFFFF8001) reset to 0 and accept writes only while intc_present_i or pwr_present_i, respectively, is 1. Bit 0 of each register drives the matching enable output, and the masked address bits drive the matching base output.
- R7: Global 0x028 reads intc_present_i and global 0x030 reads pwr_present_i, as bit 0 with all other bits 0.
- R8: Global 0x000 reads 0, global 0x010 reads parameter REV_VAL (default 0x800), and global 0x038 reads 0x00100000, with only the bypass bit 20 set. Writes to these read-only words and to per-VP 0x000 change nothing.
- R9: A reset-vector base write stores wdata_i & 0xFFFFF000. The next cycle, that VP's 64-bit slice of exc_base_o carries the stored value sign-extended from bit 31.
- R10: Misaligned offsets, unlisted offsets, window 3, and per-VP window accesses with req_vp_i >= NUM_VP are unmapped. They read 0, ignore writes, and raise unmapped_o for exactly the cycle after the access.
- R11: rdata_o updates on the clock edge that samples rd_i and holds its value while rd_i is low.
- R12: A write to global 0x008 stores wdata_i & 0xFFFF8000 into the self base, which appears on self_base_o and reads back from 0x008.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| req_vp_i | input | 3 | Index of the requesting VP |
| addr_i | input | 15 | Byte offset; bits 14:13 select the window |
| wdata_i | input | 32 | Write data |
| intc_present_i | input | 1 | Interrupt controller present |
| pwr_present_i | input | 1 | Power controller present |
| rdata_o | output | 32 | Registered read data |
| unmapped_o | output | 1 | One-cycle flag after an unmapped access |
| self_base_o | output | 32 | Block's own base address |
| intc_base_o | output | 32 | Interrupt-controller base address field |
| intc_en_o | output | 1 | Interrupt-controller enable |
| pwr_base_o | output | 32 | Power-controller base address field |
| pwr_en_o | output | 1 | Power-controller enable |
| exc_base_o | output | NUM_VP*64 | Per-VP exception base, VP n at bits n*64+63:n*64 |

## Verification
The bench builds the block with NUM_VP=5 and the default revision and self-base reset value. Five VPs is not a power of two, so the 3-bit selector can carry the values 5, 6 and 7, which must be rejected. The requester index can also reach 5 to 7, which makes out-of-range requesters on the per-VP windows reachable. The five banks let remote-window chains cross several distinct VPs, and the presence flags are toggled during random traffic, so gated peripheral writes are exercised in both states.

// File: rtl/vp_gcfg_pkg.sv
package vp_gcfg_pkg;
  localparam int DW    = 32;
  localparam int AW    = 15;
  localparam int XW    = 64;
  localparam int SEL_W = 3;

  localparam logic [DW-1:0] SELF_MSK  = 32'hFFFF_8000;
  localparam logic [DW-1:0] INTC_MSK  = 32'hFFFE_0001;
  localparam logic [DW-1:0] PWR_MSK   = 32'hFFFF_8001;
  localparam logic [DW-1:0] RB_MSK    = 32'hFFFF_F000;
  localparam logic [DW-1:0] RB_RST    = 32'hBFC0_0000;
  localparam logic [DW-1:0] CACHE_VAL = 32'h0010_0000;

  localparam logic [1:0] WIN_GLB = 2'd0;
  localparam logic [1:0] WIN_LOC = 2'd1;
  localparam logic [1:0] WIN_OTH = 2'd2;

  localparam logic [12:0] OFS_G_CFG   = 13'h000;
  localparam logic [12:0] OFS_G_SELF  = 13'h008;
  localparam logic [12:0] OFS_G_REV   = 13'h010;
  localparam logic [12:0] OFS_G_INTC  = 13'h018;
  localparam logic [12:0] OFS_G_PWR   = 13'h020;
  localparam logic [12:0] OFS_G_INTST = 13'h028;
  localparam logic [12:0] OFS_G_PWRST = 13'h030;
  localparam logic [12:0] OFS_G_CACHE = 13'h038;
  localparam logic [12:0] OFS_V_CFG   = 13'h000;
  localparam logic [12:0] OFS_V_RB    = 13'h008;
  localparam logic [12:0] OFS_V_SEL   = 13'h010;

  typedef enum logic [3:0] {
    RS_NONE, RS_G_CFG, RS_G_SELF, RS_G_REV, RS_G_INTC, RS_G_PWR,
    RS_G_INTST, RS_G_PWRST, RS_G_CACHE, RS_V_CFG, RS_V_RB, RS_V_SEL
  } reg_sel_e;

  function automatic logic [XW-1:0] sext_base(input logic [DW-1:0] v);
    return {{(XW-DW){v[DW-1]}}, v};
  endfunction
endpackage

// File: rtl/vp_gcfg_decode.sv
module vp_gcfg_decode
  import vp_gcfg_pkg::*;
(
  input  logic [AW-1:0] addr_i,
  output reg_sel_e      sel_o,
  output logic          other_o
);
  logic [1:0]  win;
  logic [12:0] ofs;

  assign win     = addr_i[14:13];
  assign ofs     = addr_i[12:0];
  assign other_o = (win == WIN_OTH);

  always_comb begin
    sel_o = RS_NONE;
    if (win == WIN_GLB) begin
      case (ofs)
        OFS_G_CFG:   sel_o = RS_G_CFG;
        OFS_G_SELF:  sel_o = RS_G_SELF;
        OFS_G_REV:   sel_o = RS_G_REV;
        OFS_G_INTC:  sel_o = RS_G_INTC;
        OFS_G_PWR:   sel_o = RS_G_PWR;
        OFS_G_INTST: sel_o = RS_G_INTST;
        OFS_G_PWRST: sel_o = RS_G_PWRST;
        OFS_G_CACHE: sel_o = RS_G_CACHE;
        default:     sel_o = RS_NONE;
      endcase
    end else if (win == WIN_LOC || win == WIN_OTH) begin
      case (ofs)
        OFS_V_CFG: sel_o = RS_V_CFG;
        OFS_V_RB:  sel_o = RS_V_RB;
        OFS_V_SEL: sel_o = RS_V_SEL;
        default:   sel_o = RS_NONE;
      endcase
    end
  end
endmodule

// File: rtl/vp_gcfg_global.sv
module vp_gcfg_global
  import vp_gcfg_pkg::*;
#(
  parameter logic [31:0] REV_VAL  = 32'h0000_0800,
  parameter logic [31:0] SELF_RST = 32'h1FBF_8000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  reg_sel_e      sel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          intc_present_i,
  input  logic          pwr_present_i,
  output logic [DW-1:0] self_base_o,
  output logic [DW-1:0] intc_reg_o,
  output logic [DW-1:0] pwr_reg_o,
  output logic [DW-1:0] rd_val_o
);
  logic [DW-1:0] self_q, intc_q, pwr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      self_q <= SELF_RST & SELF_MSK;
      intc_q <= '0;
      pwr_q  <= '0;
    end else if (wr_i) begin
      if (sel_i == RS_G_SELF) self_q <= wdata_i & SELF_MSK;
      if (sel_i == RS_G_INTC && intc_present_i) intc_q <= wdata_i & INTC_MSK;
      if (sel_i == RS_G_PWR && pwr_present_i) pwr_q <= wdata_i & PWR_MSK;
    end
  end

  always_comb begin
    case (sel_i)
      RS_G_SELF:  rd_val_o = self_q;
      RS_G_REV:   rd_val_o = REV_VAL;
      RS_G_INTC:  rd_val_o = intc_q;
      RS_G_PWR:   rd_val_o = pwr_q;
      RS_G_INTST: rd_val_o = {{(DW-1){1'b0}}, intc_present_i};
      RS_G_PWRST: rd_val_o = {{(DW-1){1'b0}}, pwr_present_i};
      RS_G_CACHE: rd_val_o = CACHE_VAL;
      default:    rd_val_o = '0;
    endcase
  end

  assign self_base_o = self_q;
  assign intc_reg_o  = intc_q;
  assign pwr_reg_o   = pwr_q;

  // R6: absent peripheral keeps its base register
  a_r6_intc_absent_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == RS_G_INTC && !intc_present_i) |=> $stable(intc_reg_o));
  a_r6_pwr_absent_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == RS_G_PWR && !pwr_present_i) |=> $stable(pwr_reg_o));
  // R12: self base only moves on its own write
  a_r12_self_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && sel_i == RS_G_SELF) |=> $stable(self_base_o));
endmodule

// File: rtl/vp_gcfg_vpbank.sv
module vp_gcfg_vpbank
  import vp_gcfg_pkg::*;
#(
  parameter int unsigned NUM_VP = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_rb_i,
  input  logic             wr_sel_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rb_o,
  output logic [SEL_W-1:0] sel_o,
  output logic [XW-1:0]    exc_o
);
  localparam logic [SEL_W:0] VP_LIM = (SEL_W+1)'(NUM_VP);

  logic [DW-1:0]    rb_q;
  logic [SEL_W-1:0] sel_q;
  logic             sel_ok;

  assign sel_ok = {1'b0, wdata_i[SEL_W-1:0]} < VP_LIM;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rb_q  <= RB_RST & RB_MSK;
      sel_q <= '0;
    end else begin
      if (wr_rb_i) rb_q <= wdata_i & RB_MSK;
      if (wr_sel_i && sel_ok) sel_q <= wdata_i[SEL_W-1:0];
    end
  end

  assign rb_o  = rb_q;
  assign sel_o = sel_q;
  assign exc_o = sext_base(rb_q);

  a_r3_sel_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, sel_o} < VP_LIM);
  a_r3_reject_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sel_i && !({1'b0, wdata_i[SEL_W-1:0]} < VP_LIM)) |=> $stable(sel_o));
  a_r9_exc_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_rb_i |=> (exc_o[DW-1:0] == ($past(wdata_i) & RB_MSK)));
  a_r9_exc_sext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o[XW-1:DW] == {(XW-DW){exc_o[DW-1]}});
endmodule

// File: rtl/vp_gcfg_regs.sv
module vp_gcfg_regs
  import vp_gcfg_pkg::*;
#(
  parameter int unsigned NUM_VP   = 4,
  parameter logic [31:0] REV_VAL  = 32'h0000_0800,
  parameter logic [31:0] SELF_RST = 32'h1FBF_8000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rd_i,
  input  logic                 wr_i,
  input  logic [2:0]           req_vp_i,
  input  logic [14:0]          addr_i,
  input  logic [31:0]          wdata_i,
  input  logic                 intc_present_i,
  input  logic                 pwr_present_i,
  output logic [31:0]          rdata_o,
  output logic                 unmapped_o,
  output logic [31:0]          self_base_o,
  output logic [31:0]          intc_base_o,
  output logic                 intc_en_o,
  output logic [31:0]          pwr_base_o,
  output logic                 pwr_en_o,
  output logic [NUM_VP*64-1:0] exc_base_o
);
  localparam logic [SEL_W:0] VP_LIM = (SEL_W+1)'(NUM_VP);
  localparam logic [DW-1:0]  CFG_VAL = DW'(NUM_VP - 1);

  reg_sel_e rsel;
  logic     other;
  logic     req_ok, vp_reg, mapped, glb_wr;

  logic [NUM_VP-1:0][SEL_W-1:0] sel_arr;
  logic [NUM_VP-1:0][DW-1:0]    rb_arr;
  logic [SEL_W-1:0] cur_sel, tgt, tsel;
  logic [DW-1:0]    trb, glb_rd, rd_val, intc_reg, pwr_reg;
  logic [DW-1:0]    rdata_q;
  logic             unm_q;

  vp_gcfg_decode u_dec (
    .addr_i  (addr_i),
    .sel_o   (rsel),
    .other_o (other)
  );

  assign req_ok = {1'b0, req_vp_i} < VP_LIM;
  assign vp_reg = (rsel == RS_V_CFG) || (rsel == RS_V_RB) || (rsel == RS_V_SEL);
  assign mapped = (rsel != RS_NONE) && (!vp_reg || req_ok);
  assign glb_wr = wr_i && mapped && !vp_reg;

  always_comb begin
    cur_sel = '0;
    for (int i = 0; i < NUM_VP; i++)
      if (req_vp_i == SEL_W'(i)) cur_sel = sel_arr[i];
  end

  assign tgt = other ? cur_sel : req_vp_i;

  always_comb begin
    trb  = '0;
    tsel = '0;
    for (int i = 0; i < NUM_VP; i++)
      if (tgt == SEL_W'(i)) begin
        trb  = rb_arr[i];
        tsel = sel_arr[i];
      end
  end

  vp_gcfg_global #(
    .REV_VAL  (REV_VAL),
    .SELF_RST (SELF_RST)
  ) u_glb (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_i           (glb_wr),
    .sel_i          (rsel),
    .wdata_i        (wdata_i),
    .intc_present_i (intc_present_i),
    .pwr_present_i  (pwr_present_i),
    .self_base_o    (self_base_o),
    .intc_reg_o     (intc_reg),
    .pwr_reg_o      (pwr_reg),
    .rd_val_o       (glb_rd)
  );

  for (genvar g = 0; g < NUM_VP; g++) begin : g_bank
    logic hit;
    assign hit = wr_i && mapped && (tgt == SEL_W'(g));
    vp_gcfg_vpbank #(.NUM_VP(NUM_VP)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_rb_i  (hit && rsel == RS_V_RB),
      .wr_sel_i (hit && rsel == RS_V_SEL),
      .wdata_i  (wdata_i),
      .rb_o     (rb_arr[g]),
      .sel_o    (sel_arr[g]),
      .exc_o    (exc_base_o[g*XW +: XW])
    );
  end

  always_comb begin
    case (rsel)
      RS_V_CFG: rd_val = CFG_VAL;
      RS_V_RB:  rd_val = trb;
      RS_V_SEL: rd_val = {{(DW-SEL_W){1'b0}}, tsel};
      default:  rd_val = glb_rd;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      unm_q   <= 1'b0;
    end else begin
      if (rd_i) rdata_q <= mapped ? rd_val : '0;
      unm_q <= (rd_i || wr_i) && !mapped;
    end
  end

  assign rdata_o     = rdata_q;
  assign unmapped_o  = unm_q;
  assign intc_base_o = {intc_reg[DW-1:1], 1'b0};
  assign intc_en_o   = intc_reg[0];
  assign pwr_base_o  = {pwr_reg[DW-1:1], 1'b0};
  assign pwr_en_o    = pwr_reg[0];

  a_r11_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
  a_r10_flag_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !wr_i) |=> !unmapped_o);
  a_r10_unmapped_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !mapped) |=> (rdata_o == '0));
  a_r6_en_off_absent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!intc_en_o && !intc_present_i) |=> !intc_en_o);
endmodule

// File: tb/vp_gcfg_regs_tb_top.sv
`timescale 1ns/1ps
module vp_gcfg_regs_tb_top;
  localparam int NV = 5;
  localparam logic [31:0] REV  = 32'h800;
  localparam logic [31:0] SRST = 32'h1FBF_8000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd = 1'b0, wr = 1'b0;
  logic [2:0]  vp = '0;
  logic [14:0] addr = '0;
  logic [31:0] wdata = '0;
  logic intc_p = 1'b0, pwr_p = 1'b0;
  logic [31:0] rdata, self_b, intc_b, pwr_b;
  logic unm, intc_en, pwr_en;
  logic [NV*64-1:0] exc;

  int errs = 0, checks = 0;
  bit done = 0;

  logic [2:0]  sel_m [NV];
  logic [31:0] rb_m  [NV];
  logic [31:0] intc_m, pwr_m, self_m;

  always #2 clk = ~clk;

  vp_gcfg_regs #(.NUM_VP(NV), .REV_VAL(REV), .SELF_RST(SRST)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .wr_i(wr), .req_vp_i(vp),
    .addr_i(addr), .wdata_i(wdata), .intc_present_i(intc_p),
    .pwr_present_i(pwr_p), .rdata_o(rdata), .unmapped_o(unm),
    .self_base_o(self_b), .intc_base_o(intc_b), .intc_en_o(intc_en),
    .pwr_base_o(pwr_b), .pwr_en_o(pwr_en), .exc_base_o(exc)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit m_unm(input logic [2:0] v, input logic [14:0] a);
    logic [12:0] o = a[12:0];
    case (a[14:13])
      2'd0: return !(o inside {13'h000, 13'h008, 13'h010, 13'h018,
                               13'h020, 13'h028, 13'h030, 13'h038});
      2'd1, 2'd2: return !(o inside {13'h000, 13'h008, 13'h010}) || (v >= NV);
      default: return 1'b1;
    endcase
  endfunction

  function automatic int m_tgt(input logic [2:0] v, input logic [14:0] a);
    return (a[14:13] == 2'd2) ? int'(sel_m[v]) : int'(v);
  endfunction

  function automatic logic [31:0] m_rd(input logic [2:0] v, input logic [14:0] a);
    int t;
    if (m_unm(v, a)) return '0;
    if (a[14:13] == 2'd0) begin
      case (a[12:0])
        13'h008: return self_m;
        13'h010: return REV;
        13'h018: return intc_m;
        13'h020: return pwr_m;
        13'h028: return {31'd0, intc_p};
        13'h030: return {31'd0, pwr_p};
        13'h038: return 32'h0010_0000;
        default: return '0;
      endcase
    end
    t = m_tgt(v, a);
    case (a[12:0])
      13'h000: return NV - 1;
      13'h008: return rb_m[t];
      default: return {29'd0, sel_m[t]};
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] v, input logic [14:0] a);
    if (m_unm(v, a)) return "R10";
    case (a[14:13])
      2'd0: return (a[12:0] == 13'h018 || a[12:0] == 13'h020) ? "R6" :
                   (a[12:0] == 13'h028 || a[12:0] == 13'h030) ? "R7" :
                   (a[12:0] == 13'h008) ? "R12" : "R8";
      2'd1: return (a[12:0] == 13'h000) ? "R5" : "R2";
      default: return (a[12:0] == 13'h000) ? "R5" : "R4";
    endcase
  endfunction

  task automatic check_outs(input string req);
    check({req, " self"}, {32'd0, self_b}, {32'd0, self_m});
    check({req, " intc"}, {31'd0, intc_en, intc_b}, {31'd0, intc_m[0], intc_m[31:1], 1'b0});
    check({req, " pwr"}, {31'd0, pwr_en, pwr_b}, {31'd0, pwr_m[0], pwr_m[31:1], 1'b0});
    for (int i = 0; i < NV; i++)
      check({req, " exc"}, exc[i*64 +: 64], {{32{rb_m[i][31]}}, rb_m[i]});
  endtask

  task automatic rd_chk(input logic [2:0] v, input logic [14:0] a, input string req);
    logic [31:0] e = m_rd(v, a);
    bit eu = m_unm(v, a);
    @(negedge clk); rd = 1'b1; vp = v; addr = a;
    @(negedge clk); rd = 1'b0;
    check(req, {32'd0, rdata}, {32'd0, e});
    check({req, " flag"}, {63'd0, unm}, {63'd0, eu});
  endtask

  task automatic wr_op(input logic [2:0] v, input logic [14:0] a, input logic [31:0] d, input string req);
    bit eu = m_unm(v, a);
    int t = m_tgt(v, a);
    @(negedge clk); wr = 1'b1; vp = v; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
    if (!eu) begin
      if (a[14:13] == 2'd0) begin
        if (a[12:0] == 13'h008) self_m = d & 32'hFFFF_8000;
        if (a[12:0] == 13'h018 && intc_p) intc_m = d & 32'hFFFE_0001;
        if (a[12:0] == 13'h020 && pwr_p) pwr_m = d & 32'hFFFF_8001;
      end else begin
        if (a[12:0] == 13'h008) rb_m[t] = d & 32'hFFFF_F000;
        if (a[12:0] == 13'h010 && d[2:0] < NV) sel_m[t] = d[2:0];
      end
    end
    check({req, " wflag"}, {63'd0, unm}, {63'd0, eu});
    check_outs(req);
  endtask

  function automatic logic [14:0] pick_addr();
    logic [14:0] tbl [14] = '{15'h0000, 15'h0008, 15'h0010, 15'h0018, 15'h0020,
      15'h0028, 15'h0030, 15'h0038, 15'h2000, 15'h2008, 15'h2010, 15'h4000,
      15'h4008, 15'h4010};
    int r = $urandom_range(0, 19);
    if (r < 14) return tbl[r];
    return 15'($urandom);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] keep;
    void'($urandom(32'd4242));
    for (int i = 0; i < NV; i++) begin sel_m[i] = '0; rb_m[i] = 32'hBFC0_0000; end
    intc_m = '0; pwr_m = '0; self_m = SRST & 32'hFFFF_8000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_outs("R1");
    check("R1 exc0", exc[63:0], 64'hFFFF_FFFF_BFC0_0000);
    for (int i = 0; i < NV; i++) begin
      rd_chk(3'(i), 15'h2010, "R1 sel");
      rd_chk(3'(i), 15'h2008, "R1 rb");
    end
    // R5
    rd_chk(3'd0, 15'h2000, "R5 local cfg");
    rd_chk(3'd3, 15'h4000, "R5 other cfg");
    // R2 / R9
    wr_op(3'd2, 15'h2008, 32'h1234_5678, "R9 local rb");
    rd_chk(3'd2, 15'h2008, "R2 own bank");
    rd_chk(3'd0, 15'h2008, "R2 other bank untouched");
    check("R9 sext positive", exc[2*64 +: 64], 64'h0000_0000_1234_5000);
    // R3
    wr_op(3'd1, 15'h2010, 32'h5, "R3 reject 5");
    rd_chk(3'd1, 15'h2010, "R3 after 5");
    wr_op(3'd1, 15'h2010, 32'hFFFF_FFF7, "R3 reject 7");
    rd_chk(3'd1, 15'h2010, "R3 after 7");
    wr_op(3'd1, 15'h2010, 32'h4, "R3 accept 4");
    rd_chk(3'd1, 15'h2010, "R3 after 4");
    // R4
    rd_chk(3'd1, 15'h4008, "R4 remote rb");
    wr_op(3'd1, 15'h4008, 32'h8000_0FFF, "R4 remote rb write");
    check("R9 sext negative", exc[4*64 +: 64], 64'hFFFF_FFFF_8000_0000);
    wr_op(3'd1, 15'h4010, 32'h2, "R4 remote sel write");
    rd_chk(3'd4, 15'h2010, "R4 remote sel landed");
    rd_chk(3'd1, 15'h2010, "R4 own sel unchanged");
    // R6 / R7
    wr_op(3'd0, 15'h0018, 32'hFFFF_FFFF, "R6 intc absent");
    rd_chk(3'd0, 15'h0028, "R7 intc absent");
    intc_p = 1'b1; pwr_p = 1'b1;
    wr_op(3'd0, 15'h0018, 32'hFFFF_FFFF, "R6 intc present");
    wr_op(3'd0, 15'h0020, 32'hABCD_EF01, "R6 pwr present");
    rd_chk(3'd0, 15'h0018, "R6 intc read");
    rd_chk(3'd0, 15'h0030, "R7 pwr present");
    pwr_p = 1'b0;
    wr_op(3'd0, 15'h0020, 32'h0, "R6 pwr absent");
    // R8
    rd_chk(3'd0, 15'h0000, "R8 cfg");
    rd_chk(3'd0, 15'h0010, "R8 rev");
    rd_chk(3'd0, 15'h0038, "R8 cache");
    wr_op(3'd0, 15'h0010, 32'h1, "R8 rev write");
    rd_chk(3'd0, 15'h0010, "R8 rev kept");
    wr_op(3'd0, 15'h2000, 32'h7, "R8 vp cfg write");
    rd_chk(3'd0, 15'h2000, "R8 vp cfg kept");
    // R12
    wr_op(3'd0, 15'h0008, 32'h1234_FFFF, "R12 self");
    rd_chk(3'd0, 15'h0008, "R12 self read");
    // R10
    rd_chk(3'd0, 15'h6000, "R10 window3");
    rd_chk(3'd0, 15'h2004, "R10 misaligned");
    rd_chk(3'd6, 15'h2008, "R10 bad requester");
    wr_op(3'd7, 15'h2010, 32'h1, "R10 bad requester write");
    wr_op(3'd0, 15'h0040, 32'hFFFF_FFFF, "R10 unlisted write");
    @(negedge clk);
    check("R10 flag one cycle", {63'd0, unm}, 64'd0);
    // R11
    rd_chk(3'd0, 15'h0010, "R11 load");
    keep = rdata;
    wr_op(3'd0, 15'h0008, 32'h0, "R11 write between");
    @(negedge clk);
    check("R11 hold", {32'd0, rdata}, {32'd0, keep});
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] v = 3'($urandom_range(0, 7));
      logic [14:0] a = pick_addr();
      if (n % 64 == 0) begin intc_p = 1'($urandom); pwr_p = 1'($urandom); end
      if ($urandom_range(0, 1) == 0) rd_chk(v, a, tag_of(v, a));
      else wr_op(v, a, $urandom, tag_of(v, a));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule